// File: doc/BRIEF.md
# Asynchronous Static Memory Bus Timing Controller

This block runs single read and write accesses to an external asynchronous static memory (SRAM, ROM or NOR-type parts) over a pin set that several banks share. Each bank has its own active-low chip select. Address, data and the output-enable, write-enable and address-valid strobes are common to all banks. Each bank has a small configuration space: a control word, a read-timing word and a write-timing word. Every phase of an access has its own programmable length in clock cycles: address setup, address hold, data and bus turnaround.

On the internal side, a requester holds a request with its bank, direction, address, lane size and write data until the block returns a one-cycle ready pulse. Read data is valid in that same cycle. On the memory side, the address and data can share the data pins. In that mode an address-hold phase separates the address from the data, and an address-valid strobe marks the setup phase. For writes, a bank can take its timing from a separate write-timing word. Writes can also be blocked for each bank.

The data pins are split into output, output-enable and input vectors, so the pad ring can build the bidirectional buffer outside the block.

Top module: `sramTimingCtl`

## Requirements
- R1: Each bank has one active-low chip select. During an access, only the addressed bank's select is low. All selects are high after reset, while idle and during turnaround.
- R2: An access keeps its chip select low for exactly S+H+D cycles. The setup phase comes first and lasts S = addSet cycles, and addSet of 0 removes it. H and D are defined in R3 to R5.
- R3: With the bank's mux bit set, a hold phase of H = max(addHld,1) cycles follows setup. Through setup and hold, the data pins drive the zero-extended access address. With the mux bit clear, H = 0 and the data pins are not driven before the data phase.
- R4: For a read, output enable is low for exactly the D = max(dataSt,1) data cycles. rspData returns the data pins as sampled on the last data cycle, masked as in R12.
- R5: For a write, the data phase lasts D = max(dataSt,2) cycles. The data pins drive the masked write data for all D cycles. Write enable is low from the first data cycle through all but the last one.
- R6: When a bank's write-enable bit is clear, a write to that bank still runs the same phase timing. Write enable stays high and the data pins are not driven in the data phase.
- R7: The address-valid strobe is low exactly during the setup cycles of an access to a bank with the mux bit set, and at no other time.
- R8: reqReady is high for exactly one cycle, the one right after the last data cycle. All chip selects are high in that cycle, and rspData is valid in it.
- R9: A request is accepted at a rising edge where the controller is idle and reqReady is low. If a request is waiting, the chip selects stay high for exactly max(busTurn,1)+1 cycles between two accesses.
- R10: When a bank's extended-mode bit is clear, reads and writes both use its read-timing word. When the bit is set, writes use the write-timing word and reads keep the read-timing word.
- R11: After reset, every control word is 0: 8-bit, not multiplexed, writes disabled, extended mode clear. Both timing words hold addSet=15, addHld=15, dataSt=255 and busTurn=15.
- R12: The number of active lanes is the smaller of reqSize and the bank width. Both use the encoding 0 = 8 bits, 1 = 16 bits, 2 or 3 = 32 bits. Lanes above that width read as zero and are driven as zero.
- R13: cfgWrite at a rising edge writes cfgData into a word of bank cfgBank chosen by cfgSel: 0 selects the control word (bit0 mux, bits 2:1 width, bit3 write enable, bit4 extended mode), 1 the read-timing word and 2 the write-timing word. Both timing words use bits 3:0 addSet, 7:4 addHld, 15:8 dataSt and 19:16 busTurn. cfgSel 3 changes nothing. An access uses the values held when it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrite | input | 1 | Configuration word write strobe |
| cfgBank | input | BANK_W | Bank whose word is written |
| cfgSel | input | 2 | Word select: control, read timing, write timing |
| cfgData | input | 32 | Configuration word value |
| reqValid | input | 1 | Access request, held until reqReady |
| reqWrite | input | 1 | 1 for write, 0 for read |
| reqBank | input | BANK_W | Target bank |
| reqAddr | input | ADDR_W | Access address |
| reqSize | input | 2 | Requested lane width |
| reqWdata | input | 32 | Write data |
| reqReady | output | 1 | One-cycle completion pulse |
| rspData | output | 32 | Read data, valid with reqReady |
| memCsN | output | NUM_BANKS | Per-bank active-low chip selects |
| memAddr | output | ADDR_W | Memory address pins |
| memDataOut | output | 32 | Value driven on the data pins |
| memDataOe | output | 1 | Data pin output enable |
| memDataIn | input | 32 | Value seen on the data pins |
| memOeN | output | 1 | Active-low output enable |
| memWeN | output | 1 | Active-low write enable |
| memAdvN | output | 1 | Active-low address-valid strobe |

## Verification
A request accepted at a rising edge pulls its chip select low in the next cycle. From that cycle on, every strobe has a fixed position inside the S+H+D-cycle window, and reqReady and rspData arrive in the first cycle after the window closes. The next chip select then falls max(busTurn,1)+1 cycles later. The bench samples at falling edges and numbers each cycle of the chip-select window. It compares every strobe and the data pins against the value the requirements give for that position. It checks ready and read data only in the cycle after the window, and it measures the turnaround gap on accesses issued back to back.

// File: rtl/sramTimingPkg.sv
package sramTimingPkg;
  localparam int DATA_W = 32;

  typedef struct packed {
    logic       extMode;
    logic       wrEn;
    logic [1:0] width;
    logic       muxEn;
  } bankCtrl_t;

  typedef struct packed {
    logic [3:0] busTurn;
    logic [7:0] dataSt;
    logic [3:0] addHld;
    logic [3:0] addSet;
  } timing_t;

  typedef struct packed {
    logic accept;
    logic capture;
    logic active;
    logic advOn;
    logic addrOnData;
    logic dataOn;
    logic oeOn;
    logic weOn;
  } strobes_t;

  localparam bankCtrl_t CTRL_RST   = '0;
  localparam timing_t   TIMING_RST = '{busTurn: 4'hF, dataSt: 8'hFF, addHld: 4'hF, addSet: 4'hF};

  function automatic logic [DATA_W-1:0] laneMask(input logic [1:0] size, input logic [1:0] width);
    logic [1:0] s, w, e;
    s = (size == 2'd3) ? 2'd2 : size;
    w = (width == 2'd3) ? 2'd2 : width;
    e = (s < w) ? s : w;
    case (e)
      2'd0:    laneMask = DATA_W'(32'h0000_00FF);
      2'd1:    laneMask = DATA_W'(32'h0000_FFFF);
      default: laneMask = '1;
    endcase
  endfunction
endpackage

// File: rtl/sramTimingCtrl.sv
module sramTimingCtrl import sramTimingPkg::*; (
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqValid,
  input  logic     reqWrite,
  input  logic     selMux,
  input  logic     selWrEn,
  input  timing_t  selTiming,
  output strobes_t strb,
  output logic     reqReady
);
  typedef enum logic [2:0] {ST_IDLE, ST_SETUP, ST_HOLD, ST_DATA, ST_TURN} state_t;

  state_t     state;
  logic [7:0] cnt;
  logic       muxQ, wrQ, wrOkQ, readyQ;
  logic [3:0] hldQ, turnQ;
  logic [7:0] datQ;
  logic       accept, lastCyc;
  logic [3:0] hldN;
  logic [7:0] datN;

  assign accept  = (state == ST_IDLE) && reqValid && !readyQ;
  assign lastCyc = (cnt == 8'd1);
  assign hldN    = (selTiming.addHld == 4'd0) ? 4'd1 : selTiming.addHld;
  always_comb begin
    if (reqWrite) datN = (selTiming.dataSt < 8'd2) ? 8'd2 : selTiming.dataSt;
    else          datN = (selTiming.dataSt == 8'd0) ? 8'd1 : selTiming.dataSt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE; cnt <= '0; readyQ <= 1'b0;
      muxQ <= 1'b0; wrQ <= 1'b0; wrOkQ <= 1'b0;
      hldQ <= '0; turnQ <= '0; datQ <= '0;
    end else begin
      readyQ <= 1'b0;
      case (state)
        ST_IDLE: if (accept) begin
          muxQ <= selMux; wrQ <= reqWrite; wrOkQ <= selWrEn;
          hldQ <= hldN; datQ <= datN; turnQ <= selTiming.busTurn;
          if (selTiming.addSet != 4'd0) begin state <= ST_SETUP; cnt <= 8'(selTiming.addSet); end
          else if (selMux)              begin state <= ST_HOLD;  cnt <= 8'(hldN); end
          else                          begin state <= ST_DATA;  cnt <= datN; end
        end
        ST_SETUP: if (lastCyc) begin
          if (muxQ) begin state <= ST_HOLD; cnt <= 8'(hldQ); end
          else      begin state <= ST_DATA; cnt <= datQ; end
        end else cnt <= cnt - 8'd1;
        ST_HOLD: if (lastCyc) begin state <= ST_DATA; cnt <= datQ; end
                 else cnt <= cnt - 8'd1;
        ST_DATA: if (lastCyc) begin
          readyQ <= 1'b1;
          if (turnQ != 4'd0) begin state <= ST_TURN; cnt <= 8'(turnQ); end
          else state <= ST_IDLE;
        end else cnt <= cnt - 8'd1;
        ST_TURN: if (lastCyc) state <= ST_IDLE;
                 else cnt <= cnt - 8'd1;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb            = '0;
    strb.accept     = accept;
    strb.active     = (state == ST_SETUP) || (state == ST_HOLD) || (state == ST_DATA);
    strb.advOn      = (state == ST_SETUP) && muxQ;
    strb.addrOnData = muxQ && ((state == ST_SETUP) || (state == ST_HOLD));
    strb.dataOn     = (state == ST_DATA) && wrQ && wrOkQ;
    strb.oeOn       = (state == ST_DATA) && !wrQ;
    strb.weOn       = (state == ST_DATA) && wrQ && wrOkQ && !lastCyc;
    strb.capture    = (state == ST_DATA) && !wrQ && lastCyc;
  end

  assign reqReady = readyQ;

  AST_READY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN) readyQ |=> !readyQ); // R8
  AST_READY_BUS_FREE: assert property (@(posedge clk) disable iff (!rstN) readyQ |-> !strb.active); // R8
  AST_HOLD_ONLY_MUX: assert property (@(posedge clk) disable iff (!rstN) (state == ST_HOLD) |-> muxQ); // R3
  AST_NO_ACCEPT_AFTER_READY: assert property (@(posedge clk) disable iff (!rstN) readyQ |=> !strb.active); // R9
endmodule

// File: rtl/sramTimingDp.sv
module sramTimingDp import sramTimingPkg::*; #(
  parameter  int NUM_BANKS = 4,
  parameter  int ADDR_W    = 24,
  localparam int BANK_W    = $clog2(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrite,
  input  logic [BANK_W-1:0] cfgBank,
  input  logic [1:0]        cfgSel,
  input  logic [DATA_W-1:0] cfgData,
  input  logic              reqWrite,
  input  logic [BANK_W-1:0] reqBank,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqSize,
  input  logic [DATA_W-1:0] reqWdata,
  input  strobes_t          strb,
  output logic              selMux,
  output logic              selWrEn,
  output timing_t           selTiming,
  output logic [DATA_W-1:0] rspData,
  output logic [NUM_BANKS-1:0] memCsN,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDataOut,
  output logic              memDataOe,
  input  logic [DATA_W-1:0] memDataIn,
  output logic              memOeN,
  output logic              memWeN,
  output logic              memAdvN
);
  bankCtrl_t ctrlQ  [NUM_BANKS];
  timing_t   rdTimQ [NUM_BANKS];
  timing_t   wrTimQ [NUM_BANKS];
  bankCtrl_t reqCtrl;
  logic [BANK_W-1:0] bankQ;
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ, maskQ, rspQ, addrBus, reqMask;
  logic cfgUnused;

  assign cfgUnused = ^cfgData[DATA_W-1:20];

  always_ff @(posedge clk) begin
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (!rstN) begin
        ctrlQ[b] <= CTRL_RST; rdTimQ[b] <= TIMING_RST; wrTimQ[b] <= TIMING_RST;
      end else if (cfgWrite && cfgBank == BANK_W'(b)) begin
        case (cfgSel)
          2'd0:    ctrlQ[b]  <= bankCtrl_t'(cfgData[4:0]);
          2'd1:    rdTimQ[b] <= timing_t'(cfgData[19:0]);
          2'd2:    wrTimQ[b] <= timing_t'(cfgData[19:0]);
          default: ;
        endcase
      end
    end
  end

  assign reqCtrl   = ctrlQ[reqBank];
  assign selMux    = reqCtrl.muxEn;
  assign selWrEn   = reqCtrl.wrEn;
  assign selTiming = (reqWrite && reqCtrl.extMode) ? wrTimQ[reqBank] : rdTimQ[reqBank];
  assign reqMask   = laneMask(reqSize, reqCtrl.width);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bankQ <= '0; addrQ <= '0; wdataQ <= '0; maskQ <= '0; rspQ <= '0;
    end else begin
      if (strb.accept) begin
        bankQ <= reqBank; addrQ <= reqAddr;
        wdataQ <= reqWdata & reqMask; maskQ <= reqMask;
      end
      if (strb.capture) rspQ <= memDataIn & maskQ;
    end
  end

  always_comb begin
    addrBus = '0;
    addrBus[ADDR_W-1:0] = addrQ;
  end

  generate
    for (genvar g = 0; g < NUM_BANKS; g++) begin : gCs
      assign memCsN[g] = !(strb.active && bankQ == BANK_W'(g));
    end
  endgenerate

  assign memAddr    = addrQ;
  assign memDataOut = strb.addrOnData ? addrBus : wdataQ;
  assign memDataOe  = strb.addrOnData || strb.dataOn;
  assign memOeN     = !strb.oeOn;
  assign memWeN     = !strb.weOn;
  assign memAdvN    = !strb.advOn;
  assign rspData    = rspQ;

  AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rstN) $onehot0(~memCsN)); // R1
  AST_WE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN) !memWeN |-> ctrlQ[bankQ].wrEn); // R6
  AST_OE_WE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN) !(!memOeN && !memWeN)); // R4
  AST_ADV_WITH_ADDR: assert property (@(posedge clk) disable iff (!rstN) !memAdvN |-> (memDataOe && memDataOut == addrBus)); // R7
  AST_STROBE_NEEDS_CS: assert property (@(posedge clk) disable iff (!rstN) (!memOeN || !memWeN) |-> !(&memCsN)); // R1
endmodule

// File: rtl/sramTimingCtl.sv
module sramTimingCtl import sramTimingPkg::*; #(
  parameter  int NUM_BANKS = 4,
  parameter  int ADDR_W    = 24,
  localparam int BANK_W    = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgWrite,
  input  logic [BANK_W-1:0]    cfgBank,
  input  logic [1:0]           cfgSel,
  input  logic [DATA_W-1:0]    cfgData,
  input  logic                 reqValid,
  input  logic                 reqWrite,
  input  logic [BANK_W-1:0]    reqBank,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [1:0]           reqSize,
  input  logic [DATA_W-1:0]    reqWdata,
  output logic                 reqReady,
  output logic [DATA_W-1:0]    rspData,
  output logic [NUM_BANKS-1:0] memCsN,
  output logic [ADDR_W-1:0]    memAddr,
  output logic [DATA_W-1:0]    memDataOut,
  output logic                 memDataOe,
  input  logic [DATA_W-1:0]    memDataIn,
  output logic                 memOeN,
  output logic                 memWeN,
  output logic                 memAdvN
);
  strobes_t strb;
  timing_t  selTiming;
  logic     selMux, selWrEn;

  sramTimingCtrl uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .selMux(selMux), .selWrEn(selWrEn), .selTiming(selTiming),
    .strb(strb), .reqReady(reqReady)
  );

  sramTimingDp #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) uDp (
    .clk(clk), .rstN(rstN), .cfgWrite(cfgWrite), .cfgBank(cfgBank), .cfgSel(cfgSel),
    .cfgData(cfgData), .reqWrite(reqWrite), .reqBank(reqBank), .reqAddr(reqAddr),
    .reqSize(reqSize), .reqWdata(reqWdata), .strb(strb), .selMux(selMux),
    .selWrEn(selWrEn), .selTiming(selTiming), .rspData(rspData), .memCsN(memCsN),
    .memAddr(memAddr), .memDataOut(memDataOut), .memDataOe(memDataOe),
    .memDataIn(memDataIn), .memOeN(memOeN), .memWeN(memWeN), .memAdvN(memAdvN)
  );
endmodule

// File: tb/sramTimingCtl_test.sv
`timescale 1ns/1ps
module sramTimingCtl_test;
  localparam int NB = 4;
  localparam int AW = 24;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWrite = 1'b0;
  logic [1:0] cfgBank = '0;
  logic [1:0] cfgSel = '0;
  logic [31:0] cfgData = '0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [1:0] reqBank = '0;
  logic [AW-1:0] reqAddr = '0;
  logic [1:0] reqSize = '0;
  logic [31:0] reqWdata = '0;
  logic reqReady;
  logic [31:0] rspData, memDataOut, memDataIn;
  logic [NB-1:0] memCsN;
  logic [AW-1:0] memAddr;
  logic memDataOe, memOeN, memWeN, memAdvN;

  int checks = 0, fails = 0, tick = 0, prevLast = 0, prevT = 0;
  logic [4:0]  shCtrl [NB];
  logic [19:0] shRd [NB];
  logic [19:0] shWr [NB];

  always #4 clk = ~clk;

  function automatic logic [31:0] pat(input logic [AW-1:0] a);
    pat = {a[7:0] ^ 8'hC3, a[15:8], a[7:0] + 8'h11, a[7:0]};
  endfunction

  function automatic logic [31:0] maskOf(input logic [1:0] size, input logic [1:0] width);
    int s, w, e;
    s = (size == 2'd3) ? 2 : int'(size);
    w = (width == 2'd3) ? 2 : int'(width);
    e = (s < w) ? s : w;
    maskOf = (e == 0) ? 32'hFF : (e == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  assign memDataIn = memOeN ? 32'h0 : pat(memAddr);

  sramTimingCtl uut (
    .clk(clk), .rstN(rstN), .cfgWrite(cfgWrite), .cfgBank(cfgBank), .cfgSel(cfgSel),
    .cfgData(cfgData), .reqValid(reqValid), .reqWrite(reqWrite), .reqBank(reqBank),
    .reqAddr(reqAddr), .reqSize(reqSize), .reqWdata(reqWdata), .reqReady(reqReady),
    .rspData(rspData), .memCsN(memCsN), .memAddr(memAddr), .memDataOut(memDataOut),
    .memDataOe(memDataOe), .memDataIn(memDataIn), .memOeN(memOeN), .memWeN(memWeN),
    .memAdvN(memAdvN)
  );

  task automatic chk(input bit ok, input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    tick++;
  endtask

  // R13: configuration word write through the normal configuration port
  task automatic cfgWr(input int bank, input int sel, input logic [31:0] val);
    cfgWrite = 1'b1; cfgBank = 2'(bank); cfgSel = 2'(sel); cfgData = val;
    step();
    cfgWrite = 1'b0;
    if (sel == 0) shCtrl[bank] = val[4:0];
    else if (sel == 1) shRd[bank] = val[19:0];
    else if (sel == 2) shWr[bank] = val[19:0];
  endtask

  task automatic access(input int bank, input bit isWr, input logic [AW-1:0] addr,
                        input logic [31:0] wdata, input logic [1:0] size, input bit b2b,
                        output int csLen);
    logic [4:0] c;
    logic [19:0] t;
    logic [31:0] mask, rdat;
    bit mux, en, first, done, eAdv, eOe, eWe;
    int S, H, D, T, k, firstCs, lastCs, readyTick, guard;
    int otherBad, advBad, oeBad, weBad, pinBad;
    c = shCtrl[bank];
    t = (isWr && c[4]) ? shWr[bank] : shRd[bank];
    mux = c[0]; en = c[3];
    mask = maskOf(size, c[2:1]);
    S = int'(t[3:0]);
    H = mux ? ((t[7:4] == 4'd0) ? 1 : int'(t[7:4])) : 0;
    if (isWr) D = (t[15:8] < 8'd2) ? 2 : int'(t[15:8]);
    else      D = (t[15:8] == 8'd0) ? 1 : int'(t[15:8]);
    T = int'(t[19:16]);
    k = 0; firstCs = -1; lastCs = 0; readyTick = 0; guard = 0; rdat = '0;
    otherBad = 0; advBad = 0; oeBad = 0; weBad = 0; pinBad = 0;
    first = 1; done = 0;
    reqValid = 1'b1; reqWrite = isWr; reqBank = 2'(bank); reqAddr = addr;
    reqSize = size; reqWdata = wdata;
    while (!done) begin
      step();
      guard++;
      if (first && b2b) chk(reqReady == 1'b0, "R8", "ready lasted two cycles", 32'(reqReady), 0);
      first = 0;
      for (int j = 0; j < NB; j++) if (j != bank && !memCsN[j]) otherBad++;
      if (!memCsN[bank]) begin
        if (firstCs < 0) firstCs = tick;
        lastCs = tick;
        eAdv = mux && (k < S);
        eOe  = !isWr && (k >= S + H);
        eWe  = isWr && en && (k >= S + H) && (k < S + H + D - 1);
        if ((!memAdvN) != eAdv) advBad++;
        if ((!memOeN) != eOe) oeBad++;
        if ((!memWeN) != eWe) weBad++;
        if (mux && k < S + H) begin
          if (!(memDataOe && memDataOut == {8'h0, addr})) pinBad++;
        end else if (k >= S + H && isWr && en) begin
          if (!(memDataOe && memDataOut == (wdata & mask))) pinBad++;
        end else if (memDataOe) pinBad++;
        k++;
      end else begin
        if (!memAdvN) advBad++;
        if (!memOeN) oeBad++;
        if (!memWeN) weBad++;
        if (memDataOe) pinBad++;
      end
      if (reqReady) begin
        done = 1; readyTick = tick; rdat = rspData;
      end else if (guard > 2000) begin
        done = 1;
        chk(1'b0, "R8", "ready never arrived", 0, 1);
      end
    end
    reqValid = 1'b0;
    csLen = k;
    chk(otherBad == 0, "R1", "other bank selected", 32'(otherBad), 0);
    chk(k == S + H + D, "R2", "chip select length", 32'(k), 32'(S + H + D));
    chk(advBad == 0, "R7", "address-valid position", 32'(advBad), 0);
    chk(oeBad == 0, "R4", "output enable position", 32'(oeBad), 0);
    chk(weBad == 0, "R5 R6", "write enable position", 32'(weBad), 0);
    chk(pinBad == 0, "R3 R5 R12", "data pin drive", 32'(pinBad), 0);
    chk(readyTick == lastCs + 1, "R8", "ready cycle", 32'(readyTick), 32'(lastCs + 1));
    if (!isWr) chk(rdat == (pat(addr) & mask), "R4 R12", "read data", rdat, pat(addr) & mask);
    if (b2b) chk(firstCs - prevLast - 1 == ((prevT < 1) ? 1 : prevT) + 1, "R9", "turnaround gap",
                 32'(firstCs - prevLast - 1), 32'(((prevT < 1) ? 1 : prevT) + 1));
    prevLast = lastCs;
    prevT = T;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int len;
    int combo;
    int sv[3] = '{0, 1, 3};
    int hv[3] = '{0, 1, 2};
    int dv[4] = '{0, 1, 2, 5};
    int tv[3] = '{0, 1, 3};
    for (int b = 0; b < NB; b++) begin
      shCtrl[b] = '0; shRd[b] = 20'hFFFFF; shWr[b] = 20'hFFFFF; // R11 reset values
    end
    repeat (3) @(negedge clk);
    chk(memCsN == '1, "R1", "reset chip selects", 32'(memCsN), 32'hF);
    chk(memOeN && memWeN && memAdvN, "R1", "reset strobes", {29'b0, memOeN, memWeN, memAdvN}, 7);
    chk(!memDataOe, "R3", "reset data drive", 32'(memDataOe), 0);
    chk(!reqReady, "R8", "reset ready", 32'(reqReady), 0);
    rstN = 1'b1;
    step();

    // R11: untouched bank uses reset timing and 8-bit width
    access(1, 1'b0, 24'h00ABCD, 32'h0, 2'd2, 1'b0, len);
    chk(len == 270, "R11", "reset read timing length", 32'(len), 270);

    // R10 R11: extended mode with write word still at reset value
    cfgWr(0, 0, 32'h1C);
    cfgWr(0, 1, 32'h00111);
    access(0, 1'b1, 24'h000123, 32'hCAFEF00D, 2'd2, 1'b0, len);
    chk(len == 270, "R11", "reset write timing length", 32'(len), 270);
    access(0, 1'b0, 24'h000456, 32'h0, 2'd2, 1'b1, len);
    chk(len == 2, "R10", "read keeps read timing", 32'(len), 2);
    cfgWr(0, 2, 32'h10302);
    access(0, 1'b1, 24'h000789, 32'h12345678, 2'd1, 1'b0, len);
    chk(len == 5, "R10", "write uses write timing", 32'(len), 5);
    cfgWr(0, 0, 32'h0C);
    access(0, 1'b1, 24'h00078A, 32'h87654321, 2'd2, 1'b0, len);
    chk(len == 3, "R10", "extended clear uses read timing", 32'(len), 3);

    // R6: write to bank with write enable clear
    cfgWr(0, 0, 32'h04);
    access(0, 1'b1, 24'h000AAA, 32'hFFFF0000, 2'd2, 1'b0, len);
    chk(len == 3, "R6", "blocked write keeps timing", 32'(len), 3);

    // R13: select value 3 changes nothing
    cfgWr(0, 3, 32'h000FF);
    access(0, 1'b0, 24'h000BBB, 32'h0, 2'd2, 1'b0, len);
    chk(len == 2, "R13", "ignored config select", 32'(len), 2);

    combo = 0;
    for (int mux = 0; mux < 2; mux++)
      for (int si = 0; si < 3; si++)
        for (int hi = 0; hi < 3; hi++)
          for (int di = 0; di < 4; di++)
            for (int ti = 0; ti < 3; ti++) begin
              int bank;
              logic [1:0] width, size;
              logic [AW-1:0] addr;
              logic [31:0] wdata;
              bank  = combo % NB;
              width = 2'(combo % 3);
              size  = 2'((combo / 3) % 4);
              addr  = AW'(combo * 24'h1357 + 24'h40);
              wdata = 32'h9E3779B9 * 32'(combo + 1);
              cfgWr(bank, 0, {27'b0, 1'b0, 1'b1, width, 1'(mux)});
              cfgWr(bank, 1, {12'b0, 4'(tv[ti]), 8'(dv[di]), 4'(hv[hi]), 4'(sv[si])});
              access(bank, 1'b0, addr, 32'h0, size, 1'b0, len);
              access(bank, 1'b1, addr ^ 24'h5, wdata, size, 1'b1, len);
              combo++;
            end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule